// File: doc/BRIEF.md
# Color channel sampling sequencer

This block steers the input multiplexer of a three-color sampling front end. A 9-bit configuration word chooses which of the red, green and blue inputs take part and in which direction they are visited. How many colors are enabled decides the mode. With three, the select cycles through all colors. With two, it alternates between them. With one, it stays put. With none, the select output is marked invalid.

Each pulse on `advance` moves the select to the next enabled color in the chosen order, wrapping around at the end. A `sync` pulse starts a new line. It forces the select back to the first enabled color of the order. It is also the only moment at which a newly written configuration word replaces the one in use, so a sequence is never reshaped halfway through.

The sequencer register holds the current color and steps through three transitions. SYNC_LOAD reloads the configuration and jumps to the first color. STEP moves to the next enabled color. HOLD keeps the color when neither strobe is active, or when no color is enabled. The current color is one of three states: ST_RED, ST_GREEN and ST_BLUE, held in an enum.

Top module: `color_seq_top`

## Requirements
- R1: After reset the stored and active configuration are both 0x0F0. The select is red, `sel_valid` is 1 and `cfg_err` is 0.
- R2: With bit 7 = 1 and bits 6,5,4 (red, green, blue enables) all set, each `advance` steps the select red, green, blue, red. `sel_code` encodes red=0, green=1 and blue=2. `sel_onehot` has bit 0 for red, bit 1 for green and bit 2 for blue. Both outputs change in the cycle after the strobe.
- R3: With bit 7 = 0 and all three enables set, each `advance` steps the select blue, green, red, blue.
- R4: With exactly two enable bits set, `advance` alternates between the two enabled colors. On a sync, the first color is the one that comes earlier in the order chosen by bit 7.
- R5: With exactly one enable bit set, the select sits on that color and `advance` leaves it unchanged.
- R6: A `sync` moves the select to the first enabled color of the order. In 3-channel mode that is red when bit 7 = 1 and blue when bit 7 = 0.
- R7: When `sync` and `advance` are high in the same cycle, the sync result applies and the advance is dropped.
- R8: A write through `cfg_wr`/`cfg_data` is stored, but sequencing keeps using the previous word until the next `sync`. A write in the same cycle as a `sync` waits for the following `sync`.
- R9: A configuration with no enable bit set makes `sel_valid` 0 from its sync on. The select keeps its last color, and `advance` has no effect.
- R10: `cfg_err` is 1 in the cycle after a write whose bit 8 or bits 3..0 are nonzero. It returns to 0 after a write with those bits clear. Those bits never affect sequencing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Store `cfg_data` as the pending configuration |
| cfg_data | input | 9 | Configuration word: bit 7 order, bits 6..4 enables |
| advance | input | 1 | Step to the next enabled color |
| sync | input | 1 | Line start: apply pending configuration, go to first color |
| sel_code | output | 2 | Encoded color select (0 red, 1 green, 2 blue) |
| sel_onehot | output | 3 | One-hot color select |
| sel_valid | output | 1 | At least one color is enabled |
| cfg_err | output | 1 | Stored word has a nonzero reserved bit |

## Verification
The `sync` and `advance` strobes can land in the same cycle. The bench provokes this in 3-channel and 2-channel modes while the select sits one step before the wrap. It expects the first color of the order, not the next color. A configuration write can also coincide with a `sync`. The bench issues a write together with a sync and expects the select and order to follow the old word until a later sync.

// File: rtl/color_seq_pkg.sv
package color_seq_pkg;

    localparam int CFG_W     = 9;
    localparam int ORDER_BIT = 7;
    localparam int EN_HI     = 6;
    localparam int EN_LO     = 4;
    localparam int N_CH      = EN_HI - EN_LO + 1;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 9'h0F0;
    localparam logic [CFG_W-1:0] RSVD_MASK   = 9'h10F;

    typedef enum logic [1:0] {
        ST_RED   = 2'd0,
        ST_GREEN = 2'd1,
        ST_BLUE  = 2'd2
    } chan_e;

    // color at a given position of the visiting order
    function automatic chan_e slot_chan(input logic rgb, input int idx);
        chan_e c;
        unique case (idx)
            0:       c = rgb ? ST_RED  : ST_BLUE;
            1:       c = ST_GREEN;
            default: c = rgb ? ST_BLUE : ST_RED;
        endcase
        return c;
    endfunction

    // position of a color within the visiting order
    function automatic int chan_slot(input logic rgb, input chan_e c);
        int p;
        unique case (c)
            ST_RED:   p = rgb ? 0 : 2;
            ST_GREEN: p = 1;
            default:  p = rgb ? 2 : 0;
        endcase
        return p;
    endfunction

    // enable vector is {red, green, blue}
    function automatic logic chan_on(input logic [N_CH-1:0] en, input chan_e c);
        logic r;
        unique case (c)
            ST_RED:   r = en[2];
            ST_GREEN: r = en[1];
            default:  r = en[0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import color_seq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          sync,
    output logic [W-1:0]  pend_q,
    output logic          act_order,
    output logic [N_CH-1:0] act_en
);

    localparam logic [W-1:0] RESET_WORD = W'(CFG_DEFAULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= RESET_WORD;
            act_order <= RESET_WORD[ORDER_BIT];
            act_en    <= RESET_WORD[EN_HI:EN_LO];
        end else begin
            if (wr) begin
                pend_q <= wdata;
            end
            if (sync) begin
                act_order <= pend_q[ORDER_BIT];
                act_en    <= pend_q[EN_HI:EN_LO];
            end
        end
    end

    // R8: a write alone never reaches the active configuration
    assert_hold_until_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sync) |=> ($stable(act_order) && $stable(act_en)));

    // R8: a sync applies the word stored before that edge
    assert_sync_applies_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (act_en == $past(pend_q[EN_HI:EN_LO]) && act_order == $past(pend_q[ORDER_BIT])));

endmodule

// File: rtl/cs_decode.sv
module cs_decode
    import color_seq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic [W-1:0]    pend_cfg,
    input  logic            act_order,
    input  logic [N_CH-1:0] act_en,
    input  chan_e           cur,
    output chan_e           first_ch,
    output logic            pend_any,
    output logic            rsvd_bad,
    output chan_e           next_ch,
    output logic [1:0]      act_count
);

    localparam logic [W-1:0] MASK = W'(RSVD_MASK);

    logic            p_order;
    logic [N_CH-1:0] p_en;

    always_comb begin
        p_order  = pend_cfg[ORDER_BIT];
        p_en     = pend_cfg[EN_HI:EN_LO];
        pend_any = |p_en;
        rsvd_bad = |(pend_cfg & MASK);

        // first enabled color of the pending order
        first_ch = slot_chan(p_order, 0);
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (chan_on(p_en, slot_chan(p_order, i))) begin
                first_ch = slot_chan(p_order, i);
            end
        end

        // next enabled color after the current one, active order
        act_count = '0;
        for (int i = 0; i < N_CH; i++) begin
            act_count = act_count + 2'(act_en[i]);
        end
        next_ch = cur;
        for (int k = N_CH - 1; k >= 1; k--) begin
            if (chan_on(act_en, slot_chan(act_order, (chan_slot(act_order, cur) + k) % N_CH))) begin
                next_ch = slot_chan(act_order, (chan_slot(act_order, cur) + k) % N_CH);
            end
        end
    end

endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
    import color_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync,
    input  logic       advance,
    input  chan_e      first_ch,
    input  logic       pend_any,
    input  chan_e      next_ch,
    input  logic [1:0] act_count,
    output chan_e      cur_q,
    output logic       valid_q,
    output logic [N_CH-1:0] onehot
);

    // state register: SYNC_LOAD, STEP, HOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= ST_RED;
            valid_q <= 1'b1;
        end else if (sync) begin
            valid_q <= pend_any;
            if (pend_any) begin
                cur_q <= first_ch;
            end
        end else if (advance && act_count != 2'd0) begin
            cur_q <= next_ch;
        end
    end

    // output decode
    always_comb begin
        unique case (cur_q)
            ST_RED:   onehot = 3'b001;
            ST_GREEN: onehot = 3'b010;
            ST_BLUE:  onehot = 3'b100;
            default:  onehot = 3'b000;
        endcase
    end

    assert_sync_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && pend_any) |=> (cur_q == $past(first_ch)));

    assert_sync_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && advance && pend_any) |=> (cur_q == $past(first_ch)));

    assert_single_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && advance && act_count == 2'd1) |=> $stable(cur_q));

    assert_pair_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && advance && act_count == 2'd2) |=> (cur_q != $past(cur_q)));

    assert_none_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_count == 2'd0) |-> !valid_q);

    assert_none_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && act_count == 2'd0) |=> $stable(cur_q));

endmodule

// File: rtl/color_seq_top.sv
module color_seq_top
    import color_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [8:0] cfg_data,
    input  logic       advance,
    input  logic       sync,
    output logic [1:0] sel_code,
    output logic [2:0] sel_onehot,
    output logic       sel_valid,
    output logic       cfg_err
);

    logic [CFG_W-1:0] pend_q;
    logic             act_order;
    logic [N_CH-1:0]  act_en;
    chan_e            first_ch;
    chan_e            next_ch;
    chan_e            cur_q;
    logic             pend_any;
    logic [1:0]       act_count;

    cs_cfg_regs #(.W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wdata     (cfg_data),
        .sync      (sync),
        .pend_q    (pend_q),
        .act_order (act_order),
        .act_en    (act_en)
    );

    cs_decode #(.W(CFG_W)) u_dec (
        .pend_cfg  (pend_q),
        .act_order (act_order),
        .act_en    (act_en),
        .cur       (cur_q),
        .first_ch  (first_ch),
        .pend_any  (pend_any),
        .rsvd_bad  (cfg_err),
        .next_ch   (next_ch),
        .act_count (act_count)
    );

    cs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (sync),
        .advance   (advance),
        .first_ch  (first_ch),
        .pend_any  (pend_any),
        .next_ch   (next_ch),
        .act_count (act_count),
        .cur_q     (cur_q),
        .valid_q   (sel_valid),
        .onehot    (sel_onehot)
    );

    assign sel_code = cur_q;

    assert_err_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_data[8] || cfg_data[3:0] != 4'd0)) |=> cfg_err);

    assert_onehot_matches_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_onehot[sel_code] && $onehot(sel_onehot));

endmodule

// File: tb/tb_color_seq_top.sv
module tb_color_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_data = '0;
    logic       advance = 1'b0;
    logic       sync = 1'b0;
    logic [1:0] sel_code;
    logic [2:0] sel_onehot;
    logic       sel_valid;
    logic       cfg_err;

    int total = 0;
    int bad = 0;

    localparam logic [1:0] R = 2'd0, G = 2'd1, B = 2'd2;

    always #10 clk = ~clk;

    color_seq_top dut (.*);

    // one clock of stimulus, outputs observed at the following falling edge
    task automatic cyc(input logic a, input logic s, input logic w, input logic [8:0] d);
        advance = a; sync = s; cfg_wr = w; cfg_data = d;
        @(negedge clk);
        advance = 1'b0; sync = 1'b0; cfg_wr = 1'b0; cfg_data = '0;
    endtask

    task automatic chk(input string req, input logic [1:0] ec, input logic ev);
        logic [2:0] eoh;
        eoh = 3'b001 << ec;
        total++;
        if (sel_code !== ec || sel_onehot !== eoh || sel_valid !== ev) begin
            bad++;
            $display("FAIL %s: code=%0d onehot=%b valid=%b expected code=%0d onehot=%b valid=%b",
                     req, sel_code, sel_onehot, sel_valid, ec, eoh, ev);
        end
    endtask

    task automatic chk_err(input string req, input logic ee);
        total++;
        if (cfg_err !== ee) begin
            bad++;
            $display("FAIL %s: cfg_err=%b expected %b", req, cfg_err, ee);
        end
    endtask

    task automatic load(input logic [8:0] w);
        cyc(1'b0, 1'b0, 1'b1, w);
        cyc(1'b0, 1'b1, 1'b0, '0);
    endtask

    task automatic t_reset();
        chk("R1 reset select", R, 1'b1);
        chk_err("R1 reset err", 1'b0);
    endtask

    task automatic t_rgb();
        cyc(1, 0, 0, '0); chk("R2 rgb step1", G, 1);
        cyc(1, 0, 0, '0); chk("R2 rgb step2", B, 1);
        cyc(1, 0, 0, '0); chk("R2 rgb wrap", R, 1);
    endtask

    task automatic t_bgr();
        load(9'h070);     chk("R6 bgr sync first", B, 1);
        cyc(1, 0, 0, '0); chk("R3 bgr step1", G, 1);
        cyc(1, 0, 0, '0); chk("R3 bgr step2", R, 1);
        cyc(1, 0, 0, '0); chk("R3 bgr wrap", B, 1);
    endtask

    task automatic t_defer();
        cyc(0, 0, 1, 9'h0F0);
        cyc(1, 0, 0, '0); chk("R8 old order kept", G, 1);
        cyc(0, 1, 0, '0); chk("R8 applied at sync", R, 1);
        cyc(1, 0, 0, '0); chk("R8 new order", G, 1);
        cyc(0, 1, 1, 9'h070); chk("R8 write with sync uses old", R, 1);
        cyc(1, 0, 0, '0); chk("R8 still rgb", G, 1);
        cyc(0, 1, 0, '0); chk("R8 later sync applies", B, 1);
    endtask

    task automatic t_pair();
        load(9'h0D0);     chk("R4 rb order1 first", R, 1);
        cyc(1, 0, 0, '0); chk("R4 rb order1 step", B, 1);
        cyc(1, 0, 0, '0); chk("R4 rb order1 back", R, 1);
        load(9'h050);     chk("R4 rb order0 first", B, 1);
        cyc(1, 0, 0, '0); chk("R4 rb order0 step", R, 1);
        load(9'h0B0);     chk("R4 gb order1 first", G, 1);
        cyc(1, 0, 0, '0); chk("R4 gb step", B, 1);
        cyc(1, 0, 0, '0); chk("R4 gb back", G, 1);
    endtask

    task automatic t_single();
        load(9'h0A0);     chk("R5 green only", G, 1);
        cyc(1, 0, 0, '0); chk("R5 hold1", G, 1);
        cyc(1, 0, 0, '0); chk("R5 hold2", G, 1);
        load(9'h010);     chk("R5 blue only", B, 1);
        cyc(1, 0, 0, '0); chk("R5 blue hold", B, 1);
    endtask

    task automatic t_collide();
        load(9'h0F0);
        cyc(1, 0, 0, '0);
        cyc(1, 0, 0, '0); chk("R7 setup at blue", B, 1);
        cyc(1, 1, 0, '0); chk("R7 sync beats advance 3ch", R, 1);
        cyc(1, 0, 0, '0);
        cyc(1, 1, 0, '0); chk("R7 sync beats advance mid", R, 1);
        load(9'h050);
        cyc(1, 0, 0, '0); chk("R7 pair setup", R, 1);
        cyc(1, 1, 0, '0); chk("R7 sync beats advance 2ch", B, 1);
    endtask

    task automatic t_none();
        load(9'h0A0);     chk("R9 setup green", G, 1);
        load(9'h080);     chk("R9 none invalid, holds", G, 0);
        cyc(1, 0, 0, '0); chk("R9 advance ignored", G, 0);
        load(9'h0F0);     chk("R9 recover", R, 1);
    endtask

    task automatic t_rsvd();
        cyc(0, 0, 1, 9'h1F0); chk_err("R10 bit8 flags", 1'b1);
        cyc(0, 1, 0, '0);     chk("R10 reserved ignored sync", R, 1);
        cyc(1, 0, 0, '0);     chk("R10 reserved ignored step", G, 1);
        cyc(0, 0, 1, 9'h0F1); chk_err("R10 bit0 flags", 1'b1);
        cyc(0, 0, 1, 9'h0F0); chk_err("R10 clears", 1'b0);
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rgb();
        t_bgr();
        t_defer();
        t_pair();
        t_single();
        t_collide();
        t_none();
        t_rsvd();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule